// File: doc/BRIEF.md
# Privilege-Checked Tagged Translation Buffer

This block is a small fully associative translation cache for one hardware thread. Each slot maps a virtual page number to a physical page number. Each slot also keeps a kernel-only permission flag and an address-space tag. A lookup presents a virtual address, the current privilege mode and the current address-space tag. One cycle later the block answers with a physical address, a permission fault or a no-mapping fault. If the lookup misses, the block starts a page-table walk and holds it open until the walker responds.

The permission check sits in front of the result register, not after it. A user-mode lookup of a kernel-only slot never places any physical address bits on the result bus. Invalidation can clear every slot at once, or only the slots that carry one address-space tag, so that the other tags keep their cached translations.

Top module: `tagged_tlb`

## Requirements
- R1: A lookup accepted (reqValid and reqReady high at a rising edge) that hits a slot with matching page number and tag, and passes the permission check, gives rspValid high with rspPaddr = {physical page, page offset} in the next cycle. No walk is raised.
- R2: A lookup that misses raises walkReq in the next cycle. walkVpn and walkAsid carry the page number and tag of that lookup, and both stay steady until walkRspValid.
- R3: A walk response with walkRspFound high installs the mapping. The pending lookup is then completed in the cycle after the response, and a later lookup of the same page and tag hits with no walk.
- R4: A walk response with walkRspFound low gives rspFault high with rspCode = 0 (no mapping) in the next cycle. Nothing is installed, so the same lookup walks again.
- R5: A user-mode lookup (reqKernel = 0) of a kernel-only slot, or of a kernel-only mapping just returned by a walk, gives rspFault with rspCode = 1 (privilege). rspValid stays low and rspPaddr stays all zero.
- R6: A kernel-mode lookup (reqKernel = 1) of a kernel-only slot completes normally. Slots that are not kernel-only serve both modes.
- R7: A hit needs the tag to match. The same page number under another tag misses and walks.
- R8: A pulse on flushAsid clears only the slots whose tag equals flushAsidVal. All other slots keep hitting.
- R9: A pulse on flushAll clears every slot.
- R10: An install uses the lowest-numbered empty slot. When no slot is empty it uses a round-robin victim pointer, which starts at slot 0 after reset and advances by one each time it is used.
- R11: Only one walk is outstanding at a time. reqReady is low while walkReq is high and rises in the cycle after the walk response.
- R12: rspValid and rspFault each last one cycle per lookup and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Lookup present |
| reqReady | output | 1 | Lookup can be accepted |
| reqVaddr | input | VPN_W+OFF_W | Virtual address of the lookup |
| reqKernel | input | 1 | 1 = kernel mode, 0 = user mode |
| reqAsid | input | ASID_W | Current address-space tag |
| rspValid | output | 1 | Translation result valid |
| rspPaddr | output | PPN_W+OFF_W | Physical address, zero unless rspValid |
| rspFault | output | 1 | Lookup faulted |
| rspCode | output | 1 | Fault type: 0 no mapping, 1 privilege |
| walkReq | output | 1 | Page-table walk wanted |
| walkVpn | output | VPN_W | Page number to walk |
| walkAsid | output | ASID_W | Tag of the walked lookup |
| walkRspValid | input | 1 | Walker answer present |
| walkRspFound | input | 1 | Walker found a mapping |
| walkRspPpn | input | PPN_W | Physical page from the walker |
| walkRspKernelOnly | input | 1 | Mapping is kernel-only |
| flushAll | input | 1 | Clear every slot |
| flushAsid | input | 1 | Clear slots of one tag |
| flushAsidVal | input | ASID_W | Tag to clear |

## Verification
The bench builds the block with four slots, six-bit page numbers, four-bit offsets, eight-bit physical pages and two-bit tags. With four slots, a fifth distinct page forces an eviction. A few more misses then walk the round-robin pointer across several slots, and stale and live tags can be mixed in one table. The six-bit page space lets the walker model choose kernel-only pages and unmapped pages from address bits, so every fault path is reached within a handful of lookups.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic latchReq;   // remember a missing lookup
    logic install;    // write walker mapping into a slot
    logic sendData;   // emit a translation next cycle
    logic sendFault;  // emit a fault next cycle
    logic faultCode;  // fault type to emit
    logic fromFill;   // result page comes from the walker
    logic flushAll;   // clear every slot
    logic flushTag;   // clear slots of one tag
  } tlbStrobes_t;

  localparam logic FAULT_NOMAP = 1'b0;
  localparam logic FAULT_PRIV  = 1'b1;
endpackage

// File: rtl/tlb_store.sv
module tlb_store
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  parameter int OFF_W   = 12,
  parameter int ASID_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  tlbStrobes_t       st,
  input  logic [VPN_W-1:0]  lkVpn,
  input  logic [OFF_W-1:0]  lkOff,
  input  logic [ASID_W-1:0] lkAsid,
  input  logic              lkKernel,
  input  logic [ASID_W-1:0] flushAsidVal,
  input  logic [PPN_W-1:0]  fillPpn,
  input  logic              fillKernelOnly,
  output logic              hit,
  output logic              hitKernelOnly,
  output logic [VPN_W-1:0]  pendVpn,
  output logic [ASID_W-1:0] pendAsid,
  output logic              pendKernel,
  output logic              rspValid,
  output logic              rspFault,
  output logic              rspCode,
  output logic [PPN_W+OFF_W-1:0] rspPaddr
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] vld, kOnly, matchVec;
  logic [VPN_W-1:0]   tagVpn  [ENTRIES];
  logic [ASID_W-1:0]  tagAsid [ENTRIES];
  logic [PPN_W-1:0]   slotPpn [ENTRIES];
  logic [OFF_W-1:0]   pendOff;
  logic [IDX_W-1:0]   rrPtr, freeIdx, victim;
  logic               haveFree;
  logic [PPN_W-1:0]   hitPpn, outPpn;
  logic [OFF_W-1:0]   outOff;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_match
    assign matchVec[i] = vld[i] && (tagVpn[i] == lkVpn) && (tagAsid[i] == lkAsid);
  end

  always_comb begin
    hitPpn = '0;
    hitKernelOnly = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (matchVec[i]) begin
        hitPpn        = hitPpn | slotPpn[i];
        hitKernelOnly = hitKernelOnly | kOnly[i];
      end
    end
  end
  assign hit = |matchVec;

  // Lowest empty slot first, else the round-robin pointer
  always_comb begin
    haveFree = 1'b0;
    freeIdx  = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!vld[i]) begin
        haveFree = 1'b1;
        freeIdx  = IDX_W'(i);
      end
    end
    victim = haveFree ? freeIdx : rrPtr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vld   <= '0;
      rrPtr <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (st.flushAll || (st.flushTag && tagAsid[i] == flushAsidVal)) vld[i] <= 1'b0;
      end
      if (st.install) begin
        vld[victim] <= 1'b1;
        if (!haveFree) rrPtr <= (rrPtr == IDX_W'(ENTRIES - 1)) ? '0 : rrPtr + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (st.install) begin
      tagVpn[victim]  <= pendVpn;
      tagAsid[victim] <= pendAsid;
      slotPpn[victim] <= fillPpn;
      kOnly[victim]   <= fillKernelOnly;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendVpn    <= '0;
      pendAsid   <= '0;
      pendOff    <= '0;
      pendKernel <= 1'b0;
    end else if (st.latchReq) begin
      pendVpn    <= lkVpn;
      pendAsid   <= lkAsid;
      pendOff    <= lkOff;
      pendKernel <= lkKernel;
    end
  end

  assign outPpn = st.fromFill ? fillPpn : hitPpn;
  assign outOff = st.fromFill ? pendOff : lkOff;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspFault <= 1'b0;
      rspCode  <= 1'b0;
      rspPaddr <= '0;
    end else begin
      rspValid <= st.sendData;
      rspFault <= st.sendFault;
      rspCode  <= st.sendFault & st.faultCode;
      rspPaddr <= st.sendData ? {outPpn, outOff} : '0;
    end
  end
endmodule

// File: rtl/tlb_ctrl.sv
module tlb_ctrl
  import tlb_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqKernel,
  input  logic        hit,
  input  logic        hitKernelOnly,
  input  logic        pendKernel,
  input  logic        walkRspValid,
  input  logic        walkRspFound,
  input  logic        walkRspKernelOnly,
  input  logic        flushAllIn,
  input  logic        flushAsidIn,
  output tlbStrobes_t st,
  output logic        reqReady,
  output logic        walkReq
);
  typedef enum logic {S_IDLE, S_WALK} state_t;
  state_t state, nextState;
  logic accept;

  assign reqReady = (state == S_IDLE);
  assign walkReq  = (state == S_WALK);
  assign accept   = reqValid && reqReady;

  always_comb begin
    st          = '0;
    st.flushAll = flushAllIn;
    st.flushTag = flushAsidIn;
    nextState   = state;
    if (accept) begin
      if (hit) begin
        if (!reqKernel && hitKernelOnly) begin
          st.sendFault = 1'b1;
          st.faultCode = FAULT_PRIV;
        end else begin
          st.sendData = 1'b1;
        end
      end else begin
        st.latchReq = 1'b1;
        nextState   = S_WALK;
      end
    end
    if (walkReq && walkRspValid) begin
      nextState = S_IDLE;
      if (walkRspFound) begin
        st.install  = 1'b1;
        st.fromFill = 1'b1;
        if (!pendKernel && walkRspKernelOnly) begin
          st.sendFault = 1'b1;
          st.faultCode = FAULT_PRIV;
        end else begin
          st.sendData = 1'b1;
        end
      end else begin
        st.sendFault = 1'b1;
        st.faultCode = FAULT_NOMAP;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end
endmodule

// File: rtl/tagged_tlb.sv
module tagged_tlb
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  parameter int OFF_W   = 12,
  parameter int ASID_W  = 8,
  localparam int VA_W   = VPN_W + OFF_W,
  localparam int PA_W   = PPN_W + OFF_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [VA_W-1:0]   reqVaddr,
  input  logic              reqKernel,
  input  logic [ASID_W-1:0] reqAsid,
  output logic              rspValid,
  output logic [PA_W-1:0]   rspPaddr,
  output logic              rspFault,
  output logic              rspCode,
  output logic              walkReq,
  output logic [VPN_W-1:0]  walkVpn,
  output logic [ASID_W-1:0] walkAsid,
  input  logic              walkRspValid,
  input  logic              walkRspFound,
  input  logic [PPN_W-1:0]  walkRspPpn,
  input  logic              walkRspKernelOnly,
  input  logic              flushAll,
  input  logic              flushAsid,
  input  logic [ASID_W-1:0] flushAsidVal
);
  tlbStrobes_t st;
  logic hit, hitKernelOnly, pendKernel;

  tlb_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKernel(reqKernel),
    .hit(hit), .hitKernelOnly(hitKernelOnly), .pendKernel(pendKernel),
    .walkRspValid(walkRspValid), .walkRspFound(walkRspFound),
    .walkRspKernelOnly(walkRspKernelOnly), .flushAllIn(flushAll),
    .flushAsidIn(flushAsid), .st(st), .reqReady(reqReady), .walkReq(walkReq)
  );

  tlb_store #(
    .ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W), .OFF_W(OFF_W), .ASID_W(ASID_W)
  ) u_store (
    .clk(clk), .rstN(rstN), .st(st),
    .lkVpn(reqVaddr[VA_W-1:OFF_W]), .lkOff(reqVaddr[OFF_W-1:0]),
    .lkAsid(reqAsid), .lkKernel(reqKernel), .flushAsidVal(flushAsidVal),
    .fillPpn(walkRspPpn), .fillKernelOnly(walkRspKernelOnly),
    .hit(hit), .hitKernelOnly(hitKernelOnly),
    .pendVpn(walkVpn), .pendAsid(walkAsid), .pendKernel(pendKernel),
    .rspValid(rspValid), .rspFault(rspFault), .rspCode(rspCode), .rspPaddr(rspPaddr)
  );
endmodule

// File: rtl/tagged_tlb_chk.sv
module tagged_tlb_chk #(
  parameter int VPN_W  = 20,
  parameter int ASID_W = 8,
  parameter int PA_W   = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic              rspValid,
  input logic [PA_W-1:0]   rspPaddr,
  input logic              rspFault,
  input logic              rspCode,
  input logic              walkReq,
  input logic [VPN_W-1:0]  walkVpn,
  input logic [ASID_W-1:0] walkAsid,
  input logic              walkRspValid,
  input logic              walkRspFound
);
  a_r1_prompt_answer: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> (rspValid || rspFault || walkReq));

  a_r2_walk_hold: assert property (@(posedge clk) disable iff (!rstN)
    (walkReq && !walkRspValid) |=> (walkReq && $stable(walkVpn) && $stable(walkAsid)));

  a_r4_nomap_fault: assert property (@(posedge clk) disable iff (!rstN)
    (walkReq && walkRspValid && !walkRspFound) |=> (rspFault && !rspCode));

  a_r5_no_paddr_on_fault: assert property (@(posedge clk) disable iff (!rstN)
    rspFault |-> (rspPaddr == '0));

  a_r11_one_walk: assert property (@(posedge clk) disable iff (!rstN)
    walkReq |-> !reqReady);

  a_r12_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(rspValid && rspFault));
endmodule

bind tagged_tlb tagged_tlb_chk #(.VPN_W(VPN_W), .ASID_W(ASID_W), .PA_W(PA_W)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .rspValid(rspValid), .rspPaddr(rspPaddr), .rspFault(rspFault), .rspCode(rspCode),
  .walkReq(walkReq), .walkVpn(walkVpn), .walkAsid(walkAsid),
  .walkRspValid(walkRspValid), .walkRspFound(walkRspFound)
);

// File: tb/tb_tagged_tlb.sv
`timescale 1ns/1ps
module tb_tagged_tlb;
  localparam int ENTRIES = 4, VPN_W = 6, PPN_W = 8, OFF_W = 4, ASID_W = 2;
  localparam int PA_W = PPN_W + OFF_W;

  logic clk = 0, rstN = 0;
  logic reqValid = 0, reqKernel = 0;
  logic [VPN_W+OFF_W-1:0] reqVaddr = '0;
  logic [ASID_W-1:0] reqAsid = '0, flushAsidVal = '0;
  logic reqReady, rspValid, rspFault, rspCode, walkReq;
  logic [PA_W-1:0] rspPaddr;
  logic [VPN_W-1:0] walkVpn;
  logic [ASID_W-1:0] walkAsid;
  logic walkRspValid = 0, walkRspFound = 0, walkRspKernelOnly = 0;
  logic [PPN_W-1:0] walkRspPpn = '0;
  logic flushAll = 0, flushAsid = 0;

  int nChecks = 0, nFails = 0;
  int qKind[$]; int qPa[$]; bit qWalk[$]; string qTag[$];
  bit walkSeen = 0;
  logic [VPN_W-1:0] curVpn; logic [ASID_W-1:0] curAsid;

  always #5 clk = ~clk;

  tagged_tlb #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W), .OFF_W(OFF_W),
               .ASID_W(ASID_W)) dut (.*);

  function automatic logic [PPN_W-1:0] ppnOf(logic [VPN_W-1:0] v, logic [ASID_W-1:0] a);
    return PPN_W'(int'(v) * 3 + int'(a) * 40 + 5);
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Walker model: kernel-only if page bit 3, unmapped if page bits 5:4 == 3
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && walkReq) begin
        check(walkVpn == curVpn, "R2 walk page", int'(walkVpn), int'(curVpn));
        check(walkAsid == curAsid, "R2 walk tag", int'(walkAsid), int'(curAsid));
        check(!reqReady, "R11 ready low during walk", int'(reqReady), 0);
        repeat (2) @(negedge clk);
        check(walkReq && walkVpn == curVpn, "R2 walk held", int'(walkReq), 1);
        walkRspValid = 1;
        walkRspFound = (walkVpn[5:4] != 2'b11);
        walkRspKernelOnly = walkVpn[3];
        walkRspPpn = ppnOf(walkVpn, walkAsid);
        @(negedge clk);
        walkRspValid = 0;
        check(reqReady, "R11 ready back after walk", int'(reqReady), 1);
      end
    end
  end

  // Monitor: pops the scoreboard on each result
  initial begin
    forever begin
      @(negedge clk);
      if (rstN) begin
        if (walkReq) walkSeen = 1;
        check(!(rspValid && rspFault), "R12 exclusive", int'(rspFault), 0);
        if (rspValid || rspFault) begin
          if (qKind.size() == 0) begin
            check(0, "R12 unexpected result", 1, 0);
          end else begin
            int ek, ep, ak; bit ew; string t;
            ek = qKind.pop_front(); ep = qPa.pop_front();
            ew = qWalk.pop_front(); t = qTag.pop_front();
            ak = rspFault ? (rspCode ? 2 : 1) : 0;
            check(ak == ek, {t, " kind"}, ak, ek);
            check(int'(rspPaddr) == ep, {t, " paddr"}, int'(rspPaddr), ep);
            check(walkSeen == ew, {t, " walked"}, int'(walkSeen), int'(ew));
          end
          walkSeen = 0;
        end
      end
    end
  end

  // kind: 0 translation, 1 no-mapping fault, 2 privilege fault
  task automatic lookup(logic [VPN_W-1:0] vpn, logic [OFF_W-1:0] off, logic [ASID_W-1:0] asid,
                        bit kern, int kind, bit walked, string tag);
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    curVpn = vpn; curAsid = asid;
    reqVaddr = {vpn, off}; reqAsid = asid; reqKernel = kern; reqValid = 1;
    qKind.push_back(kind);
    qPa.push_back(kind == 0 ? int'({ppnOf(vpn, asid), off}) : 0);
    qWalk.push_back(walked); qTag.push_back(tag);
    @(posedge clk);
    @(negedge clk);
    reqValid = 0;
    if (!walked) check(rspValid || rspFault, {tag, " R1 next-cycle answer"}, 0, 1);
    while (qKind.size() != 0) @(negedge clk);
  endtask

  task automatic pulseFlush(bit all, logic [ASID_W-1:0] tagv);
    @(negedge clk);
    flushAll = all; flushAsid = !all; flushAsidVal = tagv;
    @(negedge clk);
    flushAll = 0; flushAsid = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check(reqReady && !rspValid && !rspFault && !walkReq, "R11 R12 reset state", 0, 1);

    // R10 R3 R1: fill four slots, then evict in round-robin order
    lookup(6'd1, 4'h3, 2'd1, 0, 0, 1, "R3 fill 1");
    lookup(6'd2, 4'h4, 2'd1, 0, 0, 1, "R3 fill 2");
    lookup(6'd4, 4'h5, 2'd1, 0, 0, 1, "R3 fill 4");
    lookup(6'd5, 4'h6, 2'd1, 0, 0, 1, "R3 fill 5");
    lookup(6'd1, 4'h9, 2'd1, 0, 0, 0, "R1 hit 1");
    lookup(6'd2, 4'ha, 2'd1, 1, 0, 0, "R1 hit 2");
    lookup(6'd4, 4'hb, 2'd1, 0, 0, 0, "R1 hit 4");
    lookup(6'd5, 4'hc, 2'd1, 0, 0, 0, "R1 hit 5");
    lookup(6'd6, 4'h1, 2'd1, 0, 0, 1, "R10 fill 6 evicts slot0");
    lookup(6'd1, 4'h2, 2'd1, 0, 0, 1, "R10 page 1 evicted");
    lookup(6'd4, 4'h2, 2'd1, 0, 0, 0, "R10 page 4 kept");
    lookup(6'd5, 4'h2, 2'd1, 0, 0, 0, "R10 page 5 kept");
    lookup(6'd6, 4'h2, 2'd1, 0, 0, 0, "R10 page 6 kept");
    lookup(6'd2, 4'h2, 2'd1, 0, 0, 1, "R10 page 2 evicted second");

    // R9 full flush
    pulseFlush(1, '0);
    lookup(6'd5, 4'h7, 2'd1, 0, 0, 1, "R9 page 5 cleared");
    lookup(6'd1, 4'h7, 2'd1, 0, 0, 1, "R9 page 1 cleared");

    // R7 tag must match
    lookup(6'd5, 4'h8, 2'd2, 0, 0, 1, "R7 other tag misses");
    lookup(6'd5, 4'h8, 2'd1, 0, 0, 0, "R7 tag1 hit");
    lookup(6'd5, 4'h8, 2'd2, 0, 0, 0, "R7 tag2 hit");

    // R8 tagged flush
    pulseFlush(0, 2'd2);
    lookup(6'd5, 4'h1, 2'd2, 0, 0, 1, "R8 tag2 cleared");
    lookup(6'd5, 4'h1, 2'd1, 0, 0, 0, "R8 tag1 page 5 kept");
    lookup(6'd1, 4'h1, 2'd1, 0, 0, 0, "R8 tag1 page 1 kept");

    pulseFlush(1, '0);
    // R4 no mapping
    lookup(6'h30, 4'h2, 2'd0, 0, 1, 1, "R4 no mapping");
    lookup(6'h30, 4'h2, 2'd0, 1, 1, 1, "R4 not installed");

    // R5 privilege, R6 kernel access
    lookup(6'd8, 4'h3, 2'd0, 0, 2, 1, "R5 user on kernel fill");
    lookup(6'd8, 4'h3, 2'd0, 0, 2, 0, "R5 user on kernel slot");
    lookup(6'd8, 4'hd, 2'd0, 1, 0, 0, "R6 kernel on kernel slot");
    lookup(6'd2, 4'he, 2'd0, 1, 0, 1, "R6 kernel fills user page");
    lookup(6'd2, 4'hf, 2'd0, 0, 0, 0, "R6 user on user page");

    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule